// File: doc/BRIEF.md
# Logic Analyzer Capture Controller

This block sequences one capture of an embedded logic analyzer. It writes probe words into a circular sample memory of `DEPTH` entries so that a programmable number of samples come before the trigger. The trigger is a single bit from a separate comparator. The controller drives the memory write address, write enable and write data. It also keeps a pointer to the oldest stored sample, so that host software can rotate the memory image and place the first sample at index zero.

Software sets a pre-trigger length and a mode while the controller is idle. It then pulses a start bit and polls the state until the capture is complete. A pulse on the stop bit returns the controller to idle from any state. In single-shot mode, the controller first fills the pre-trigger window. It then keeps overwriting the oldest entry until the trigger arrives, and then writes the remaining post-trigger samples. In immediate mode, it fills the whole memory at once and does not wait for a trigger.

Top module: `la_capture_ctrl`

## Requirements
- R1: After reset the state reads 0 (idle), write enable is low, the oldest-sample pointer is 0, the pre-trigger length is DEPTH/2 and the mode is single-shot (mode bit 0).
- R2: A 0-to-1 change of `start_i` seen while idle begins a capture. The next state is 1 (filling) for single-shot with a pre-trigger length above 0, 2 (armed) for single-shot with a length of 0, and 3 (post-trigger) for immediate mode. A start change outside idle is ignored, and a start level held high does not start a capture again.
- R3: A 0-to-1 change of `stop_i` puts the controller in idle (state 0) on the next clock edge from any state, with write enable low. It takes precedence over a simultaneous start.
- R4: In filling state the controller writes exactly `loc` samples at addresses 0 upward, and it ignores `trigger_i` throughout that state.
- R5: In armed state the controller writes one sample each cycle at the next circular address. While no trigger is seen, the oldest-sample pointer advances with the write address.
- R6: After the trigger, exactly DEPTH−`loc` samples are written, counting the trigger sample. The state then becomes 4 (captured) with write enable low. When `loc` equals DEPTH, the trigger cycle writes nothing and the capture ends there.
- R7: Once captured, reading the memory from the oldest-sample pointer onward places the trigger sample at index `loc` (for `loc` below DEPTH).
- R8: Immediate mode (mode bit 1) writes DEPTH consecutive samples from address 0 starting at the cycle after the start edge, without any trigger, and leaves the oldest-sample pointer at 0.
- R9: Configuration writes take effect only while idle and are ignored in every other state. A written length above DEPTH is stored as DEPTH.
- R10: Write data equals `probe_i` in the cycle of the write. The write address steps by one per write and wraps modulo DEPTH, and the final oldest-sample pointer equals the total write count of the capture modulo DEPTH.
- R11: The state code is 0 idle, 1 filling, 2 armed, 3 post-trigger, 4 captured. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request bit, acted on at its rising edge |
| stop_i | input | 1 | Stop request bit, acted on at its rising edge |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_loc_i | input | $clog2(DEPTH)+1 | Pre-trigger length to write |
| cfg_mode_i | input | 1 | Mode to write: 0 single-shot, 1 immediate |
| trigger_i | input | 1 | Trigger condition from the comparator |
| probe_i | input | PW | Probe word sampled this cycle |
| mem_we_o | output | 1 | Sample memory write enable |
| mem_addr_o | output | $clog2(DEPTH) | Sample memory write address |
| mem_wdata_o | output | PW | Sample memory write data |
| state_o | output | 3 | Current state code |
| rd_ptr_o | output | $clog2(DEPTH) | Address of the oldest stored sample |

## Verification
Two pairs of events can land on the same clock edge. A stop edge can arrive together with a start edge. A trigger can already be high when the filling phase begins. The bench raises `start_i` and `stop_i` at the same edge and expects the controller to stay idle. In a separate test it holds `trigger_i` high from before the start and expects the trigger to be taken only on the first armed cycle. That test checks for exactly DEPTH writes and an oldest-sample pointer of 0. The memory image is rebuilt in the bench from the write port. It is then judged by where the trigger sample lands after rotation.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FILL  = 3'd1,
    ST_ARMED = 3'd2,
    ST_POST  = 3'd3,
    ST_DONE  = 3'd4
  } cap_state_e;

  localparam logic MODE_SINGLE = 1'b0;
  localparam logic MODE_IMMED  = 1'b1;
endpackage

// File: rtl/la_cap_edge.sv
module la_cap_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/la_cap_cfg.sv
module la_cap_cfg #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idle_i,
  input  logic          we_i,
  input  logic [LW-1:0] loc_i,
  input  logic          mode_i,
  output logic [LW-1:0] loc_o,
  output logic          mode_o
);
  import la_cap_pkg::*;

  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);
  localparam logic [LW-1:0] HALF_L  = LW'(DEPTH / 2);

  logic [LW-1:0] loc_q;
  logic          mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loc_q  <= HALF_L;
      mode_q <= MODE_SINGLE;
    end else if (we_i && idle_i) begin
      loc_q  <= (loc_i > DEPTH_L) ? DEPTH_L : loc_i;
      mode_q <= mode_i;
    end
  end

  assign loc_o  = loc_q;
  assign mode_o = mode_q;

  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> ($stable(loc_q) && $stable(mode_q)));

  // R9
  cfg_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_q <= DEPTH_L);
endmodule

// File: rtl/la_cap_fsm.sv
module la_cap_fsm #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_rise_i,
  input  logic          stop_rise_i,
  input  logic          trig_i,
  input  logic [LW-1:0] loc_i,
  input  logic          mode_i,
  output logic [2:0]    state_o,
  output logic          we_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o
);
  import la_cap_pkg::*;

  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);
  localparam logic [LW-1:0] ONE_L   = LW'(1);
  localparam logic [AW-1:0] LAST_A  = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST_A) ? '0 : p + 1'b1;
  endfunction

  cap_state_e    state_q;
  logic [AW-1:0] wr_q, rd_q;
  logic [LW-1:0] cnt_q;
  logic [LW-1:0] post_len;
  logic          full_pre;

  assign post_len = DEPTH_L - loc_i;
  assign full_pre = (loc_i == DEPTH_L);

  // no write on the trigger cycle when the whole buffer is pre-trigger
  always_comb begin
    unique case (state_q)
      ST_FILL, ST_POST: we_o = 1'b1;
      ST_ARMED:         we_o = !(trig_i && full_pre);
      default:          we_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
    end else if (stop_rise_i) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_rise_i) begin
          wr_q <= '0;
          rd_q <= '0;
          if (mode_i == MODE_IMMED) begin
            state_q <= ST_POST;
            cnt_q   <= DEPTH_L;
          end else if (loc_i == '0) begin
            state_q <= ST_ARMED;
          end else begin
            state_q <= ST_FILL;
            cnt_q   <= loc_i;
          end
        end
        ST_FILL: begin
          wr_q  <= ptr_inc(wr_q);
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == ONE_L) state_q <= ST_ARMED;
        end
        ST_ARMED: begin
          if (trig_i) begin
            if (full_pre) begin
              state_q <= ST_DONE;
            end else begin
              wr_q <= ptr_inc(wr_q);
              if (post_len == ONE_L) begin
                state_q <= ST_DONE;
              end else begin
                state_q <= ST_POST;
                cnt_q   <= post_len - 1'b1;
              end
            end
          end else begin
            wr_q <= ptr_inc(wr_q);
            rd_q <= ptr_inc(rd_q);
          end
        end
        ST_POST: begin
          wr_q  <= ptr_inc(wr_q);
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == ONE_L) state_q <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  assign state_o  = state_q;
  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;

  // R3
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_rise_i |=> (state_q == ST_IDLE && !we_o));

  // R2
  start_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_rise_i && !stop_rise_i && state_q == ST_IDLE) |=> state_q != ST_IDLE);

  // R4
  fill_no_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL && !stop_rise_i) |=> (state_q == ST_FILL || state_q == ST_ARMED));

  // R5
  armed_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ARMED |->
      ((int'(wr_q) - int'(rd_q) + DEPTH) % DEPTH) == (int'(loc_i) % DEPTH));

  // R6
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DONE |-> !we_o);

  // R10
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && $past(we_o)) |-> wr_q == ptr_inc($past(wr_q)));

  // R11
  state_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd4);
endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl #(
  parameter int DEPTH = 1024,
  parameter int PW    = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          cfg_we_i,
  input  logic [LW-1:0] cfg_loc_i,
  input  logic          cfg_mode_i,
  input  logic          trigger_i,
  input  logic [PW-1:0] probe_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [PW-1:0] mem_wdata_o,
  output logic [2:0]    state_o,
  output logic [AW-1:0] rd_ptr_o
);
  logic          start_rise, stop_rise;
  logic [LW-1:0] loc;
  logic          mode;

  la_cap_edge u_start_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (start_i),
    .rise_o(start_rise)
  );

  la_cap_edge u_stop_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (stop_i),
    .rise_o(stop_rise)
  );

  la_cap_cfg #(.DEPTH(DEPTH)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .idle_i(state_o == 3'd0),
    .we_i  (cfg_we_i),
    .loc_i (cfg_loc_i),
    .mode_i(cfg_mode_i),
    .loc_o (loc),
    .mode_o(mode)
  );

  la_cap_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_rise_i(start_rise),
    .stop_rise_i (stop_rise),
    .trig_i      (trigger_i),
    .loc_i       (loc),
    .mode_i      (mode),
    .state_o     (state_o),
    .we_o        (mem_we_o),
    .wr_ptr_o    (mem_addr_o),
    .rd_ptr_o    (rd_ptr_o)
  );

  assign mem_wdata_o = probe_i;
endmodule

// File: tb/sim_la_capture_ctrl.sv
module sim_la_capture_ctrl;
  localparam int DEPTH = 16;
  localparam int PW    = 8;
  localparam int AW    = 4;
  localparam int LW    = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, stop = 1'b0, cfg_we = 1'b0, cfg_mode = 1'b0, trig = 1'b0;
  logic [LW-1:0] cfg_loc = '0;
  logic [PW-1:0] probe = '0;
  logic          we;
  logic [AW-1:0] addr, rd_ptr;
  logic [PW-1:0] wdata;
  logic [2:0]    state;

  logic [PW-1:0] bmem [DEPTH];
  int            wcnt = 0;
  int            total = 0, bad = 0;
  logic [PW-1:0] tv;

  always #5 clk = ~clk;

  la_capture_ctrl #(.DEPTH(DEPTH), .PW(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .cfg_we_i(cfg_we), .cfg_loc_i(cfg_loc), .cfg_mode_i(cfg_mode),
    .trigger_i(trig), .probe_i(probe), .mem_we_o(we), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .state_o(state), .rd_ptr_o(rd_ptr)
  );

  always @(negedge clk) probe <= probe + 1'b1;

  always @(posedge clk) if (we) begin
    bmem[addr] <= wdata;
    wcnt <= wcnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rot(input int i);
    return int'(bmem[(int'(rd_ptr) + i) % DEPTH]);
  endfunction

  function automatic int contig();
    for (int i = 0; i < DEPTH - 1; i++)
      if (PW'(rot(i) + 1) != PW'(rot(i + 1))) return 0;
    return 1;
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic cfg_set(input int loc, input logic mode);
    @(negedge clk); cfg_we = 1'b1; cfg_loc = LW'(loc); cfg_mode = mode;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wait_state(input int s);
    for (int n = 0; n < 2000 && int'(state) != s; n++) @(negedge clk);
  endtask

  task automatic fire();
    @(negedge clk); #1; tv = probe; trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 state", int'(state), 0);
    chk("R1 we", int'(we), 0);
    chk("R1 rd_ptr", int'(rd_ptr), 0);
  endtask

  task automatic t_default_single();
    int w0;
    w0 = wcnt;
    pulse_start();
    chk("R2 fill state", int'(state), 1);
    wait_state(2);
    chk("R1 default loc fills DEPTH/2", wcnt - w0, DEPTH / 2);
    repeat (5) @(negedge clk);
    fire();
    wait_state(4);
    @(negedge clk);
    chk("R6 we low when captured", int'(we), 0);
    chk("R7 trigger at loc", rot(DEPTH / 2), int'(tv));
    chk("R6 last post sample", rot(DEPTH - 1), int'(PW'(tv + 7)));
    chk("R5 contiguous", contig(), 1);
    chk("R10 rd_ptr vs writes", int'(rd_ptr), (wcnt - w0) % DEPTH);
    pulse_start();
    chk("R2 start ignored in captured", int'(state), 4);
    pulse_stop();
    chk("R3 stop from captured", int'(state), 0);
  endtask

  task automatic t_loc_zero();
    cfg_set(0, 1'b0);
    pulse_start();
    chk("R2 armed on loc 0", int'(state), 2);
    repeat (3) @(negedge clk);
    fire();
    wait_state(4);
    chk("R7 trigger at index 0", rot(0), int'(tv));
    chk("R6 full post window", rot(DEPTH - 1), int'(PW'(tv + DEPTH - 1)));
    pulse_stop();
  endtask

  task automatic t_loc_full();
    cfg_set(DEPTH, 1'b0);
    pulse_start();
    wait_state(2);
    repeat (4) @(negedge clk);
    fire();
    chk("R6 done at trigger when loc=DEPTH", int'(state), 4);
    chk("R6 no trigger write", rot(DEPTH - 1), int'(PW'(tv - 1)));
    chk("R5 contiguous full pre", contig(), 1);
    pulse_stop();
  endtask

  task automatic t_clamp();
    int w0;
    cfg_set(DEPTH + 9, 1'b0);
    w0 = wcnt;
    pulse_start();
    wait_state(2);
    chk("R9 clamp to DEPTH", wcnt - w0, DEPTH);
    pulse_stop();
  endtask

  task automatic t_cfg_locked();
    int w0;
    cfg_set(4, 1'b0);
    pulse_start();
    wait_state(2);
    cfg_set(10, 1'b1);
    repeat (2) @(negedge clk);
    fire();
    wait_state(4);
    chk("R9 write ignored while busy", rot(4), int'(tv));
    pulse_stop();
    w0 = wcnt;
    pulse_start();
    chk("R9 mode kept single-shot", int'(state), 1);
    wait_state(2);
    chk("R9 loc kept at 4", wcnt - w0, 4);
    pulse_stop();
  endtask

  task automatic t_trig_in_fill();
    int w0;
    cfg_set(3, 1'b0);
    w0 = wcnt;
    @(negedge clk); trig = 1'b1;
    pulse_start();
    wait_state(4);
    trig = 1'b0;
    chk("R4 trigger ignored while filling", wcnt - w0, DEPTH);
    chk("R4 rd_ptr 0", int'(rd_ptr), 0);
    pulse_stop();
  endtask

  task automatic t_stop_mid();
    cfg_set(8, 1'b0);
    pulse_start();
    wait_state(2);
    repeat (2) @(negedge clk);
    fire();
    chk("R6 post state", int'(state), 3);
    pulse_stop();
    chk("R3 stop mid capture", int'(state), 0);
    chk("R3 we low after stop", int'(we), 0);
  endtask

  task automatic t_start_stop_same();
    @(negedge clk); start = 1'b1; stop = 1'b1;
    @(negedge clk);
    chk("R3 stop beats start", int'(state), 0);
    start = 1'b0; stop = 1'b0;
  endtask

  task automatic t_immediate();
    int w0;
    cfg_set(5, 1'b1);
    w0 = wcnt;
    pulse_start();
    chk("R8 immediate post state", int'(state), 3);
    wait_state(4);
    chk("R8 DEPTH writes", wcnt - w0, DEPTH);
    chk("R8 rd_ptr 0", int'(rd_ptr), 0);
    chk("R8 contiguous", contig(), 1);
    pulse_stop();
  endtask

  task automatic t_wrap();
    int w0;
    cfg_set(5, 1'b0);
    w0 = wcnt;
    pulse_start();
    wait_state(2);
    repeat (20) @(negedge clk);
    fire();
    wait_state(4);
    chk("R10 rd_ptr after wrap", int'(rd_ptr), (wcnt - w0) % DEPTH);
    chk("R7 trigger at loc after wrap", rot(5), int'(tv));
    chk("R10 wdata contiguous", contig(), 1);
    @(negedge clk); start = 1'b1;
    pulse_stop();
    repeat (2) @(negedge clk);
    chk("R2 held start no restart", int'(state), 0);
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_single();
    t_loc_zero();
    t_loc_full();
    t_clamp();
    t_cfg_locked();
    t_trig_in_fill();
    t_stop_mid();
    t_start_stop_same();
    t_immediate();
    t_wrap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule